// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps track of the packets held in a network receiver's data FIFO and presents a 16-bit status word for the oldest packet, the head, for software to read. The receive MAC reports three events: a frame start, each byte it writes, and a frame end that carries a 4-bit error code. The block keeps a circular queue of packet records. Each record holds a byte count, an error code and a finished bit. While the head packet is still arriving, its byte count in the status word updates as bytes come in.

The host side reads packet bytes one at a time and removes the head record with a discard command. The block watches record capacity and data capacity. When either runs out, it sets a diagnostic flag and refuses new frames. It also flags a read that runs past the end of the head packet, and it raises adapter failure for that case until a receive reset clears the queue.

Top module: `rx_status_queue`

## Requirements
- R1: With no records queued, the status word is 0x8000 and rx_complete is low.
- R2: While the head packet is still arriving, the status word has bit 15 set, bits 14..11 zero and bits 10..0 equal to the bytes written so far. rx_complete is low and flag_receiving is high.
- R3: For a finished head packet, the status word has bit 15 clear, bits 14..11 equal to the error code given at frame end (for example 1101 CRC, 0010 dribble, 0000 none) and bits 10..0 equal to its byte count. rx_complete is high.
- R4: cmd_valid with cmd_op equal to 0x08 removes a finished head record, and the next record in arrival order becomes the head. The command has no effect when the queue is empty or the head is still arriving. Any other opcode has no effect.
- R5: flag_stat_ovr is high while DEPTH records are queued. A frame start in that state is refused: flag_receiving stays low and the frame's bytes and end are ignored. The flag clears once a record is removed.
- R6: When the data held reaches DATA_CAP bytes, flag_rx_ovr is set, further bytes are dropped and new frames are refused. The flag clears once at least OVR_HYST bytes are free again, whether freed by reads or by discards (a discard frees the unread rest of the head).
- R7: A byte read with the queue empty, or with as many bytes already read from the head as its byte count, sets flag_rx_underrun and adapter_fail. The flag stays set until rx_reset or rst_n.
- R8: rx_reset clears all records, counts and flags within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_reset | input | 1 | Synchronous receive reset |
| frm_start | input | 1 | MAC starts a frame |
| byte_wr | input | 1 | MAC writes one byte of the current frame |
| frm_end | input | 1 | MAC ends the current frame |
| frm_err | input | 4 | Error code given with frm_end |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command opcode; 0x08 discards the head |
| rd_byte | input | 1 | Host reads one byte of the head packet |
| status_word | output | 16 | Head packet status |
| rx_complete | output | 1 | Head is a finished packet |
| flag_receiving | output | 1 | A frame is being written |
| flag_stat_ovr | output | 1 | Record capacity exhausted |
| flag_rx_ovr | output | 1 | Data capacity exhausted |
| flag_rx_underrun | output | 1 | Read past the end of the head packet |
| adapter_fail | output | 1 | Adapter failure indication |

## Verification
A wrong head or tail pointer appears in the status word on the next cycle after a discard, because it shows the wrong byte count or error code. A wrong record count shows up when the queue is filled: the status-overrun flag rises one frame early or late, or an empty queue still reports a packet after exactly DEPTH discards. A wrong data-occupancy value shows up only when the data-overrun flag sets or clears, so the bench walks occupancy across both of its thresholds byte by byte. The failure is then seen in the very cycle the mistake is made.

// File: rtl/rx_status_queue.sv
module rx_status_queue #(
  parameter int DEPTH    = 8,
  parameter int DATA_CAP = 64,
  parameter int OVR_HYST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        frm_start,
  input  logic        byte_wr,
  input  logic        frm_end,
  input  logic [3:0]  frm_err,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  input  logic        rd_byte,
  output logic [15:0] status_word,
  output logic        rx_complete,
  output logic        flag_receiving,
  output logic        flag_stat_ovr,
  output logic        flag_rx_ovr,
  output logic        flag_rx_underrun,
  output logic        adapter_fail
);
  localparam int LW = 11;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int UW = $clog2(DATA_CAP + 1);
  localparam logic [4:0] DISC_OP = 5'h08;

  logic [LW-1:0] len_q [DEPTH];
  logic [3:0]    err_q [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [PW-1:0] hd, tl, cur;
  logic [CW-1:0] cnt;
  logic [UW-1:0] used, used_n;
  logic [LW-1:0] rd_cnt;
  logic rcv, ovr, unf;

  logic [LW-1:0] head_len;
  logic head_done, has_rec, do_disc, do_start, do_wr, rd_ok, do_rd, bad_rd;

  assign has_rec   = cnt != '0;
  assign head_len  = len_q[hd];
  assign head_done = has_rec && done_q[hd];
  assign do_disc   = cmd_valid && cmd_op == DISC_OP && head_done;
  assign do_start  = frm_start && !rcv && cnt != CW'(DEPTH) && !ovr;
  assign do_wr     = byte_wr && rcv && used != UW'(DATA_CAP);
  assign rd_ok     = has_rec && rd_cnt < head_len;
  assign do_rd     = rd_byte && !do_disc && rd_ok;
  assign bad_rd    = rd_byte && !do_disc && !rd_ok;

  always_comb begin
    used_n = used + UW'(do_wr) - UW'(do_rd);
    if (do_disc) used_n = used_n - UW'(head_len - rd_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd <= '0; tl <= '0; cur <= '0; cnt <= '0; used <= '0; rd_cnt <= '0;
      rcv <= 1'b0; ovr <= 1'b0; unf <= 1'b0; done_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        len_q[i] <= '0; err_q[i] <= '0;
      end
    end else if (rx_reset) begin
      hd <= '0; tl <= '0; cur <= '0; cnt <= '0; used <= '0; rd_cnt <= '0;
      rcv <= 1'b0; ovr <= 1'b0; unf <= 1'b0; done_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        len_q[i] <= '0; err_q[i] <= '0;
      end
    end else begin
      if (do_start) begin
        len_q[tl]  <= '0;
        err_q[tl]  <= '0;
        done_q[tl] <= 1'b0;
        cur <= tl;
        tl  <= tl + PW'(1);
        rcv <= 1'b1;
      end
      if (do_wr) len_q[cur] <= len_q[cur] + LW'(1);
      if (frm_end && rcv) begin
        done_q[cur] <= 1'b1;
        err_q[cur]  <= frm_err;
        rcv <= 1'b0;
      end
      if (do_disc) begin
        hd <= hd + PW'(1);
        rd_cnt <= '0;
      end else if (do_rd) begin
        rd_cnt <= rd_cnt + LW'(1);
      end
      cnt  <= cnt + CW'(do_start) - CW'(do_disc);
      used <= used_n;
      if (used_n == UW'(DATA_CAP)) ovr <= 1'b1;
      else if (UW'(DATA_CAP) - used_n >= UW'(OVR_HYST)) ovr <= 1'b0;
      if (bad_rd) unf <= 1'b1;
    end
  end

  assign status_word = !has_rec    ? 16'h8000 :
                       done_q[hd]  ? {1'b0, err_q[hd], head_len} :
                                     {1'b1, 4'b0000, head_len};
  assign rx_complete      = head_done;
  assign flag_receiving   = rcv;
  assign flag_stat_ovr    = cnt == CW'(DEPTH);
  assign flag_rx_ovr      = ovr;
  assign flag_rx_underrun = unf;
  assign adapter_fail     = unf;
endmodule

module rx_status_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_reset,
  input logic        frm_start,
  input logic        rd_byte,
  input logic [15:0] status_word,
  input logic        rx_complete,
  input logic        flag_receiving,
  input logic        flag_stat_ovr,
  input logic        flag_rx_underrun
);
  p_incomplete_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_complete |-> status_word[15]);
  p_finished_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |-> !status_word[15]);
  p_refuse_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_stat_ovr && frm_start && !flag_receiving |=> !flag_receiving);
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rx_underrun && !rx_reset |=> flag_rx_underrun);
  p_underrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rx_underrun) |-> $past(rd_byte));
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> status_word == 16'h8000 && !flag_rx_underrun && !flag_receiving);
endmodule

bind rx_status_queue rx_status_queue_chk u_chk (.*);

// File: tb/test_rx_status_queue.sv
module test_rx_status_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_reset = 0, frm_start = 0, byte_wr = 0, frm_end = 0, cmd_valid = 0, rd_byte = 0;
  logic [3:0] frm_err = '0;
  logic [4:0] cmd_op = '0;
  logic [15:0] status_word;
  logic rx_complete, flag_receiving, flag_stat_ovr, flag_rx_ovr, flag_rx_underrun, adapter_fail;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  rx_status_queue i_rx_status_queue (.*);

  // op[23:20] 0 start 1 byte 2 end(arg=err) 3 discard 4 read; expected status word
  localparam logic [23:0] VEC [13] = '{
    {4'd0, 4'h0, 16'h8000}, {4'd1, 4'h0, 16'h8001}, {4'd1, 4'h0, 16'h8002},
    {4'd2, 4'hD, 16'h6802}, {4'd0, 4'h0, 16'h6802}, {4'd1, 4'h0, 16'h6802},
    {4'd2, 4'h0, 16'h6802}, {4'd3, 4'h0, 16'h0001}, {4'd4, 4'h0, 16'h0001},
    {4'd3, 4'h0, 16'h8000}, {4'd0, 4'h0, 16'h8000}, {4'd2, 4'h2, 16'h1000},
    {4'd3, 4'h0, 16'h8000}};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input int kind, input logic [3:0] arg);
    case (kind)
      0: frm_start = 1;
      1: byte_wr = 1;
      2: begin frm_end = 1; frm_err = arg; end
      3: begin cmd_valid = 1; cmd_op = 5'h08; end
      4: rd_byte = 1;
      5: begin cmd_valid = 1; cmd_op = 5'h09; end
      default: rx_reset = 1;
    endcase
    @(posedge clk); #1;
    frm_start = 0; byte_wr = 0; frm_end = 0; cmd_valid = 0; rd_byte = 0; rx_reset = 0;
    frm_err = '0; cmd_op = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk); #1;
    rst_n = 1;
    chk("R1 empty word", status_word, 16'h8000);
    chk("R1 empty complete", {15'd0, rx_complete}, 16'd0);

    for (int i = 0; i < 13; i++) begin
      op(int'(VEC[i][23:20]), VEC[i][19:16]);
      chk($sformatf("R2/R3/R4 vec%0d word", i), status_word, VEC[i][15:0]);
      chk($sformatf("R2/R3 vec%0d complete", i), {15'd0, rx_complete}, {15'd0, ~VEC[i][15]});
    end

    // R2 receiving flag and discard ignored while head arrives (R4)
    op(0, 0); op(1, 0);
    chk("R2 receiving", {15'd0, flag_receiving}, 16'd1);
    op(3, 0);
    chk("R4 discard of arriving head ignored", status_word, 16'h8001);
    op(2, 0); op(3, 0);
    chk("R4 empty after discard", status_word, 16'h8000);

    // R5 status overrun
    for (int i = 0; i < 8; i++) begin op(0, 0); op(1, 0); op(2, 0); end
    chk("R5 stat ovr set", {15'd0, flag_stat_ovr}, 16'd1);
    op(0, 0);
    chk("R5 start refused", {15'd0, flag_receiving}, 16'd0);
    op(1, 0); op(2, 0);
    op(5, 0);
    chk("R4 other opcode no effect", {15'd0, flag_stat_ovr}, 16'd1);
    op(3, 0);
    chk("R5 stat ovr cleared", {15'd0, flag_stat_ovr}, 16'd0);
    for (int i = 0; i < 7; i++) op(3, 0);
    chk("R5 refused frame not queued", status_word, 16'h8000);

    // R6 data overrun
    op(0, 0);
    for (int i = 0; i < 70; i++) op(1, 0);
    chk("R6 rx ovr set", {15'd0, flag_rx_ovr}, 16'd1);
    op(2, 0);
    chk("R6 bytes dropped", status_word, 16'h0040);
    op(0, 0);
    chk("R6 start refused", {15'd0, flag_receiving}, 16'd0);
    op(1, 0); op(2, 0);
    for (int i = 0; i < 3; i++) op(4, 0);
    chk("R6 ovr held below hysteresis", {15'd0, flag_rx_ovr}, 16'd1);
    op(4, 0);
    chk("R6 ovr cleared", {15'd0, flag_rx_ovr}, 16'd0);
    op(3, 0);
    chk("R6 refused frame not queued", status_word, 16'h8000);

    // R7 underrun
    op(0, 0); op(1, 0); op(1, 0); op(2, 0);
    op(4, 0); op(4, 0);
    chk("R7 in-range reads", {15'd0, flag_rx_underrun}, 16'd0);
    op(4, 0);
    chk("R7 underrun set", {15'd0, flag_rx_underrun}, 16'd1);
    chk("R7 adapter fail", {15'd0, adapter_fail}, 16'd1);
    op(3, 0); op(0, 0); op(1, 0);
    chk("R7 underrun sticky", {15'd0, flag_rx_underrun}, 16'd1);

    // R8 rx reset
    op(6, 0);
    chk("R8 word cleared", status_word, 16'h8000);
    chk("R8 flags cleared", {12'd0, flag_receiving, flag_rx_underrun, flag_rx_ovr, flag_stat_ovr}, 16'd0);
    op(0, 0); op(1, 0); op(2, 0);
    chk("R8 queue usable after reset", status_word, 16'h0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule